// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the synchronised input levels of one 32-pin bank, organised as four ports of eight pins. It decides every clock cycle whether each pin has a pending interrupt event. Each pin carries a three-bit trigger type, a pending status bit and an enable bit. A write-one-to-clear register and masked write aliases let software update single pins without a read-modify-write. The enabled pending bits of all four ports are ORed into a single bank interrupt line.

Edge detection compares the pin's level in the current cycle with its level in the previous cycle. Status is updated whether or not the pin is enabled, so enabling a pin with a pending event raises the bank interrupt at once. A pin in level mode has a status bit that simply tracks its active level. A pin in edge mode latches its status until software clears it, and an edge that arrives in the same cycle as the clear is kept.

The register bus is a plain single-cycle port. A write is accepted on every cycle `wr_en` is high, so there is no back-pressure. Read data is a combinational function of `rd_addr`. Port p's copy of each register sits at base + 4·p.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is active, and in the first cycle after it, every status, enable and trigger-type register reads zero and `bank_irq` is low.
- R2: The trigger register of port p (offset 0x60+4p) holds three byte lanes. Pin n uses bit n as polarity (1 = high or rising), bit 8+n as edge select, and bit 16+n as both-edges select. The register reads back what was written.
- R3: Type 0b011 (bit16, bit8, bit0) is rising edge. Status sets at the first clock edge at which the pin is sampled high after being sampled low. A falling transition does not set it.
- R4: Type 0b010 is falling edge. Status sets only on a high-to-low transition.
- R5: Type 0b110 is both edges. Status sets on either transition.
- R6: When bit 8+n is 0 the pin is level triggered: 0b001 is active high and 0b000 is active low. Its status equals "level matches polarity" one cycle later, so a clear has no lasting effect while the level persists.
- R7: Writing the clear register (0x70+4p) clears status bit n of port p for each data bit n that is 1. Zero bits and other ports are unaffected.
- R8: If a clear and a new edge on the same edge-mode pin fall in the same cycle, the status stays set.
- R9: `bank_irq` is high exactly when some pin of some port has both status and enable set. Status updates even while enable is 0.
- R10: The enable register (0x50+4p) takes plain writes of data[7:0]. Its masked alias (0xD0+4p) updates only pins whose bit is set in data[15:8], taking their values from data[7:0].
- R11: The masked trigger alias (0xE0+4p) updates the three type bits of only those pins whose bit is set in data[31:24], taking the lanes from data[23:0].
- R12: The masked status alias (0xC0+4p) sets or clears the status of edge-mode pins selected by data[15:8] to the values in data[7:0]. The status registers read at 0x40+4p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronised pin levels, pin n of port p at bit 8p+n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Combinational read data |
| bank_irq | output | 1 | OR of enabled pending status over the bank |

## Verification
The main detection path is driven with single-pin rising pulses, falling pulses and pin toggles under each of the five trigger types. Each trigger type must react to the transitions it is meant to catch and ignore the others. Level pins are held at their active level while a clear is written, which shows that level status is recomputed while edge status is latched. A clear that coincides with a new edge tells apart the design that lets the event win from one that lets the clear win. Enables are toggled on ports that already hold pending status, which separates status capture from interrupt gating. Masked writes that touch one pin confirm that neighbouring pins keep their state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef struct packed {
    logic both;      // lane 2: react to either transition
    logic edge_sel;  // lane 1: 1 = edge, 0 = level
    logic pol;       // lane 0: 1 = high / rising
  } trig_t;

  // Event condition for one pin in one cycle.
  function automatic logic trig_event(trig_t t, logic cur, logic prv);
    if (!t.edge_sel) return cur == t.pol;
    if (t.both)      return cur ^ prv;
    return t.pol ? (cur & ~prv) : (~cur & prv);
  endfunction

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_t trig,
  input  logic  lvl,
  input  logic  clr,
  input  logic  sw_we,
  input  logic  sw_val,
  output logic  status
);

  logic prv_q;
  logic st_q;
  logic ev;
  logic kept;
  logic st_d;

  always_comb begin
    ev   = trig_event(trig, lvl, prv_q);
    kept = sw_we ? sw_val : (st_q & ~clr);
    // level pins recompute, edge pins latch; a fresh edge always wins
    st_d = trig.edge_sel ? (kept | ev) : ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      prv_q <= lvl;
      st_q  <= st_d;
    end
  end

  assign status = st_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8,
  localparam int TW  = 3 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic            enb_we,
  input  logic [PINS-1:0] enb_msk,
  input  logic [PINS-1:0] enb_val,
  input  logic            typ_we,
  input  logic [PINS-1:0] typ_msk,
  input  logic [TW-1:0]   typ_val,
  input  logic [PINS-1:0] clr,
  input  logic            sts_we,
  input  logic [PINS-1:0] sts_msk,
  input  logic [PINS-1:0] sts_val,
  output logic [PINS-1:0] status,
  output logic [PINS-1:0] enable,
  output logic [TW-1:0]   trig_type,
  output logic            pending
);

  logic [PINS-1:0] enb_q;
  logic [TW-1:0]   typ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_q <= '0;
      typ_q <= '0;
    end else begin
      for (int n = 0; n < PINS; n++) begin
        if (enb_we && enb_msk[n]) enb_q[n] <= enb_val[n];
        for (int l = 0; l < 3; l++) begin
          if (typ_we && typ_msk[n]) typ_q[l*PINS+n] <= typ_val[l*PINS+n];
        end
      end
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    trig_t t;
    assign t = '{both: typ_q[2*PINS+n], edge_sel: typ_q[PINS+n], pol: typ_q[n]};
    gpio_irq_pin u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (t),
      .lvl    (pin_in[n]),
      .clr    (clr[n]),
      .sw_we  (sts_we & sts_msk[n]),
      .sw_val (sts_val[n]),
      .status (status[n])
    );
  end

  assign enable    = enb_q;
  assign trig_type = typ_q;
  assign pending   = |(status & enb_q);

endmodule

// File: rtl/gpio_irq_regif.sv
module gpio_irq_regif #(
  parameter int              PORTS   = 4,
  parameter int              PINS    = 8,
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 32,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] ENB_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] TYP_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] UP_OFS  = 8'h80,
  localparam int PORT_W = $clog2(PORTS),
  localparam int TW     = 3 * PINS
) (
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [PORTS-1:0]            enb_we,
  output logic [PORTS-1:0][PINS-1:0]  enb_msk,
  output logic [PORTS-1:0][PINS-1:0]  enb_val,
  output logic [PORTS-1:0]            typ_we,
  output logic [PORTS-1:0][PINS-1:0]  typ_msk,
  output logic [PORTS-1:0][TW-1:0]    typ_val,
  output logic [PORTS-1:0][PINS-1:0]  clr,
  output logic [PORTS-1:0]            sts_we,
  output logic [PORTS-1:0][PINS-1:0]  sts_msk,
  output logic [PORTS-1:0][PINS-1:0]  sts_val
);

  localparam logic [ADDR_W-1:0] MSTS_OFS = STS_OFS + UP_OFS;
  localparam logic [ADDR_W-1:0] MENB_OFS = ENB_OFS + UP_OFS;
  localparam logic [ADDR_W-1:0] MTYP_OFS = TYP_OFS + UP_OFS;

  logic [ADDR_W-5:0] grp;
  logic [PORT_W-1:0] wport;
  logic              ok;

  assign grp   = wr_addr[ADDR_W-1:4];
  assign wport = wr_addr[2 +: PORT_W];
  assign ok    = wr_en && (wr_addr[1:0] == 2'b00);

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      logic hit;
      hit        = ok && (wport == PORT_W'(p));
      enb_we[p]  = 1'b0;
      enb_msk[p] = '1;
      enb_val[p] = wr_data[PINS-1:0];
      typ_we[p]  = 1'b0;
      typ_msk[p] = '1;
      typ_val[p] = wr_data[TW-1:0];
      clr[p]     = '0;
      sts_we[p]  = 1'b0;
      sts_msk[p] = wr_data[2*PINS-1:PINS];
      sts_val[p] = wr_data[PINS-1:0];
      if (hit) begin
        if (grp == ENB_OFS[ADDR_W-1:4]) enb_we[p] = 1'b1;
        if (grp == MENB_OFS[ADDR_W-1:4]) begin
          enb_we[p]  = 1'b1;
          enb_msk[p] = wr_data[2*PINS-1:PINS];
        end
        if (grp == TYP_OFS[ADDR_W-1:4]) typ_we[p] = 1'b1;
        if (grp == MTYP_OFS[ADDR_W-1:4]) begin
          typ_we[p]  = 1'b1;
          typ_msk[p] = wr_data[DATA_W-1 -: PINS];
        end
        if (grp == CLR_OFS[ADDR_W-1:4])  clr[p]    = wr_data[PINS-1:0];
        if (grp == MSTS_OFS[ADDR_W-1:4]) sts_we[p] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PORTS  = 4,
  parameter int PINS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int NPIN   = PORTS * PINS,
  localparam int PORT_W = $clog2(PORTS),
  localparam int TW     = 3 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              bank_irq
);

  localparam logic [ADDR_W-1:0] STS_OFS = 8'h40;
  localparam logic [ADDR_W-1:0] ENB_OFS = 8'h50;
  localparam logic [ADDR_W-1:0] TYP_OFS = 8'h60;

  logic [PORTS-1:0]            enb_we, typ_we, sts_we;
  logic [PORTS-1:0][PINS-1:0]  enb_msk, enb_val, typ_msk, clr, sts_msk, sts_val;
  logic [PORTS-1:0][TW-1:0]    typ_val;
  logic [PORTS-1:0][PINS-1:0]  sts_all, enb_all;
  logic [PORTS-1:0][TW-1:0]    typ_all;
  logic [PORTS-1:0]            pend;

  gpio_irq_regif #(
    .PORTS(PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STS_OFS(STS_OFS), .ENB_OFS(ENB_OFS), .TYP_OFS(TYP_OFS)
  ) u_regif (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .enb_we  (enb_we),
    .enb_msk (enb_msk),
    .enb_val (enb_val),
    .typ_we  (typ_we),
    .typ_msk (typ_msk),
    .typ_val (typ_val),
    .clr     (clr),
    .sts_we  (sts_we),
    .sts_msk (sts_msk),
    .sts_val (sts_val)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_irq_port #(.PINS(PINS)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_lvl[p*PINS +: PINS]),
      .enb_we    (enb_we[p]),
      .enb_msk   (enb_msk[p]),
      .enb_val   (enb_val[p]),
      .typ_we    (typ_we[p]),
      .typ_msk   (typ_msk[p]),
      .typ_val   (typ_val[p]),
      .clr       (clr[p]),
      .sts_we    (sts_we[p]),
      .sts_msk   (sts_msk[p]),
      .sts_val   (sts_val[p]),
      .status    (sts_all[p]),
      .enable    (enb_all[p]),
      .trig_type (typ_all[p]),
      .pending   (pend[p])
    );
  end

  assign bank_irq = |pend;

  logic [PORT_W-1:0] rport;
  assign rport = rd_addr[2 +: PORT_W];

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr[ADDR_W-1:4] == STS_OFS[ADDR_W-1:4]) rd_data[PINS-1:0] = sts_all[rport];
      if (rd_addr[ADDR_W-1:4] == ENB_OFS[ADDR_W-1:4]) rd_data[PINS-1:0] = enb_all[rport];
      if (rd_addr[ADDR_W-1:4] == TYP_OFS[ADDR_W-1:4]) rd_data[TW-1:0]   = typ_all[rport];
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  localparam int TW   = 3 * PINS
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [PORTS*PINS-1:0]      pin_lvl,
  input logic [PORTS-1:0][PINS-1:0] sts_all,
  input logic [PORTS-1:0][PINS-1:0] enb_all,
  input logic [PORTS-1:0][TW-1:0]   typ_all,
  input logic                       bank_irq
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sts_all == '0 && enb_all == '0 && typ_all == '0 && !bank_irq)); // R1

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> ((sts_all & enb_all) != '0)); // R9

  AST_IRQ_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_irq |-> ((sts_all & enb_all) == '0)); // R9

  for (genvar p = 0; p < PORTS; p++) begin : g_p
    for (genvar n = 0; n < PINS; n++) begin : g_n
      AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(typ_all[p][PINS+n]))
          |-> (sts_all[p][n] == ($past(pin_lvl[p*PINS+n]) == $past(typ_all[p][n])))); // R6

      AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && typ_all[p][2*PINS+n] == 1'b0 && typ_all[p][PINS+n] && typ_all[p][n]
          && pin_lvl[p*PINS+n] && !$past(pin_lvl[p*PINS+n]))
          |=> sts_all[p][n]); // R3
    end
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PORTS(PORTS), .PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_lvl  (pin_lvl),
  .sts_all  (sts_all),
  .enb_all  (enb_all),
  .typ_all  (typ_all),
  .bank_irq (bank_irq)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

  localparam logic [7:0] STS  = 8'h40;
  localparam logic [7:0] ENB  = 8'h50;
  localparam logic [7:0] TYP  = 8'h60;
  localparam logic [7:0] CLR  = 8'h70;
  localparam logic [7:0] MSTS = 8'hC0;
  localparam logic [7:0] MENB = 8'hD0;
  localparam logic [7:0] MTYP = 8'hE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        bank_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
    bit          is_irq;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bank_irq(bank_irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_lvl = v;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.exp = e; it.req = r; it.is_irq = 1'b0;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    @(negedge clk);
    it.exp = {31'b0, e}; it.req = r; it.is_irq = 1'b1;
    q.push_back(it);
  endtask

  // monitor: compares mid-low-phase, well away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'b0, bank_irq} : rd_data;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pv;
    pv = '0;
    // R1 reset state
    chk(STS, 32'h0, "R1 status in reset");
    chk(ENB, 32'h0, "R1 enable in reset");
    chk(TYP, 32'h0, "R1 type in reset");
    chk_irq(1'b0, "R1 irq in reset");
    @(negedge clk); rst_n = 1'b1;
    // R6 default type is level low, pins low
    chk(STS, 32'hFF, "R6 level-low after reset");
    chk_irq(1'b0, "R9 pending but disabled");

    // rising edge on port 0
    wr(TYP, 32'h00FFFF);
    chk(TYP, 32'h00FFFF, "R2 type readback");
    chk(STS, 32'hFF, "R6 edge mode keeps status");
    wr(CLR, 32'h0F);
    chk(STS, 32'hF0, "R7 partial clear");
    wr(CLR, 32'hF0);
    chk(STS, 32'h00, "R7 clear rest");
    chk(STS + 8'hC, 32'hFF, "R7 other port untouched");
    pv[0] = 1'b1; pins(pv);
    chk(STS, 32'h01, "R3 rising sets");
    pv[0] = 1'b0; pins(pv);
    chk(STS, 32'h01, "R3 falling holds");
    wr(CLR, 32'h01);
    chk(STS, 32'h00, "R3 cleared, fall no set");

    // falling
    wr(TYP, 32'h00FF00);
    pv[1] = 1'b1; pins(pv);
    chk(STS, 32'h00, "R4 rise ignored");
    pv[1] = 1'b0; pins(pv);
    chk(STS, 32'h02, "R4 fall sets");
    wr(CLR, 32'h02);

    // both edges
    wr(TYP, 32'hFFFF00);
    pv[2] = 1'b1; pins(pv);
    chk(STS, 32'h04, "R5 rise sets");
    wr(CLR, 32'h04);
    chk(STS, 32'h00, "R5 cleared");
    pv[2] = 1'b0; pins(pv);
    chk(STS, 32'h04, "R5 fall sets");
    wr(CLR, 32'h04);

    // level high on port 1
    wr(TYP + 8'h4, 32'h0000FF);
    chk(STS + 8'h4, 32'h00, "R6 level high inactive");
    pv[11] = 1'b1; pins(pv);
    chk(STS + 8'h4, 32'h08, "R6 level high active");
    wr(CLR + 8'h4, 32'h08);
    chk(STS + 8'h4, 32'h08, "R6 clear has no lasting effect");
    pv[11] = 1'b0; pins(pv);
    chk(STS + 8'h4, 32'h00, "R6 follows level down");

    // interrupt aggregation
    chk_irq(1'b0, "R9 idle");
    wr(ENB, 32'h01);
    chk_irq(1'b0, "R9 enabled but no status");
    pv[0] = 1'b1; pins(pv);
    chk_irq(1'b1, "R9 enabled status raises irq");
    chk(STS, 32'h01, "R9 status port0");
    wr(CLR, 32'h01);
    chk_irq(1'b0, "R9 clear drops irq");
    wr(ENB + 8'hC, 32'h80);
    chk_irq(1'b1, "R9 port3 pending while disabled");

    // masked enable
    wr(MENB + 8'hC, 32'h00008000);
    chk(ENB + 8'hC, 32'h00, "R10 masked clear");
    chk_irq(1'b0, "R10 irq after masked clear");
    wr(ENB + 8'hC, 32'h10);
    wr(MENB + 8'hC, 32'h00000202);
    chk(ENB + 8'hC, 32'h12, "R10 masked set keeps neighbour");
    wr(ENB + 8'hC, 32'h00);

    // masked type
    wr(MTYP + 8'h8, 32'h0100FFFF);
    chk(TYP + 8'h8, 32'h000101, "R11 masked type pin0");
    wr(MTYP + 8'h8, 32'h02FF0000);
    chk(TYP + 8'h8, 32'h020101, "R11 masked type pin1");

    // masked status on port 0 (both-edge mode)
    wr(MSTS, 32'h00003030);
    chk(STS, 32'h30, "R12 masked status set");
    wr(MSTS, 32'h00001000);
    chk(STS, 32'h20, "R12 masked status clear one");
    wr(CLR, 32'h20);
    chk(STS, 32'h00, "R12 cleared");

    // clear and edge together
    @(negedge clk);
    pv[6] = 1'b1; pin_lvl = pv;
    wr_en = 1'b1; wr_addr = CLR; wr_data = 32'h40;
    @(negedge clk);
    wr_en = 1'b0;
    chk(STS, 32'h40, "R8 edge wins over clear");
    wr(CLR, 32'h40);
    chk(STS, 32'h00, "R8 later clear works");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule